// File: doc/BRIEF.md
# SDRAM Burst Read Data Sequencer

This block is the device side of a 16-bit synchronous DRAM during a burst read. A read command supplies a bank and a start column. If that bank is open, the block fetches one word per clock from a small internal storage array. The first word comes from the start column. Each later column is produced internally. Words reach the data pins after a CAS latency of two or three cycles. The pin drivers switch on one cycle before the first word and switch off by themselves after the last word.

Burst length is one, two, four, eight or a full page of 256 columns. In full-page mode the burst runs until a stop command arrives. The upper and lower byte lanes can each be blanked through their own mask input, with a fixed two-cycle mask delay. A read to a closed bank raises an error pulse and produces no data. A legal read that arrives mid-burst takes over the data bus as soon as its own latency has elapsed.

The storage array is loaded through a plain one-word write port. Banks are opened and closed with activate and precharge strobes.

Top module: `sdr_burst_reader`

## Requirements
- R1: The word at the start column of a legal read in cycle c appears on `dq_out` in cycle c+2 when `cfg_cl3`=0 and in cycle c+3 when `cfg_cl3`=1.
- R2: Later words follow one per clock. Word i comes from column `(col & ~(L-1)) | ((col+i) & (L-1))`, where L is the burst length. `cfg_blen` selects L: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page with L=256, which wraps around the whole row.
- R3: Both lane enables rise in cycle c+CL-1, one cycle before the first word, and stay high through every word of the burst. During that lead cycle `dq_out` is zero.
- R4: After the last word of a fixed-length burst, both lane enables fall in the next cycle with no command.
- R5: A full-page burst continues until `stop_cmd` is sampled in cycle s. The last word is then driven in cycle s+CL-1, and the drivers are off from cycle s+CL. In a fixed-length mode, `stop_cmd` has no effect.
- R6: A high level on `dqm_hi` (upper byte, bits 15:8) or `dqm_lo` (lower byte, bits 7:0) sampled in cycle m clears only that lane's enable in cycle m+2, for either latency. A lane that is not enabled shows zero on `dq_out`.
- R7: A read in cycle c to a bank that is not open pulses `rd_err` in cycle c+1. It produces no data and leaves any running burst unchanged. `act_cmd` opens a bank and `pre_cmd` closes it, each effective from the next cycle.
- R8: A legal read in cycle c2 during a burst lets the old words continue through cycle c2+CL-1. The new burst's first word follows in cycle c2+CL.
- R9: After reset, no lane is enabled, `rd_err` is low and every bank is closed.
- R10: A word written through `wr_en` in cycle w is returned by a read issued in cycle w+1 or later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_cmd | input | 1 | Open the bank in `act_bank` |
| act_bank | input | 1 | Bank to open |
| pre_cmd | input | 1 | Close the bank in `pre_bank` |
| pre_bank | input | 1 | Bank to close |
| rd_cmd | input | 1 | Burst read command |
| rd_bank | input | 1 | Bank of the read |
| rd_col | input | 8 | Start column of the read |
| stop_cmd | input | 1 | Ends a full-page burst |
| cfg_cl3 | input | 1 | 0: CAS latency 2, 1: CAS latency 3 |
| cfg_blen | input | 3 | Burst length code (see R2) |
| dqm_hi | input | 1 | Upper byte mask |
| dqm_lo | input | 1 | Lower byte mask |
| wr_en | input | 1 | Array load strobe |
| wr_bank | input | 1 | Bank of the loaded word |
| wr_col | input | 8 | Column of the loaded word |
| wr_data | input | 16 | Loaded word |
| dq_out | output | 16 | Read data, zero in lanes that are not driven |
| dq_oe_hi | output | 1 | Upper lane driver enable (low impedance) |
| dq_oe_lo | output | 1 | Lower lane driver enable (low impedance) |
| rd_err | output | 1 | Pulse for a read to a closed bank |

## Verification
The assertions assume that `cfg_cl3` and `cfg_blen` stay constant from a read command until its last word has left. They also assume that `stop_cmd`, `act_cmd` and `pre_cmd` never share a cycle with `rd_cmd`, and that no array word is loaded while it may be read. The stimulus follows these rules. It changes configuration only after a drain period, preceded by a stop when full-page mode is set. It drives at most one command per cycle and performs all loads while the data path is idle. Within those limits, the random phase mixes legal reads, reads to closed banks, stops in both fixed and full-page modes, bank open and close, and per-cycle byte masks.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

    // Column mask covering one burst block; -1 means the whole row.
    function automatic int len_mask(input logic [2:0] code);
        case (code)
            LEN_2:    return 1;
            LEN_4:    return 3;
            LEN_8:    return 7;
            LEN_PAGE: return -1;
            default:  return 0;
        endcase
    endfunction

    function automatic logic is_page(input logic [2:0] code);
        return code == LEN_PAGE;
    endfunction

endpackage

// File: rtl/sdr_bank_state.sv
module sdr_bank_state #(
    parameter int BANK_W = 1,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_cmd,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              pre_cmd,
    input  logic [BANK_W-1:0] pre_bank,
    output logic [NBANK-1:0]  bank_on
);
    logic [NBANK-1:0] open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (pre_cmd) open_d[pre_bank] = 1'b0;
        if (act_cmd) open_d[act_bank] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= open_d;
    end

    assign bank_on = open_q;

    a_r9_closed_after_reset: assert property (@(posedge clk)
        !rst_n |=> open_q == '0);
endmodule

// File: rtl/sdr_col_seq.sv
module sdr_col_seq #(
    parameter int BANK_W = 1,
    parameter int COL_W  = 8,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              stop_cmd,
    input  logic [2:0]        len_code,
    input  logic [NBANK-1:0]  bank_on,
    output logic              iss_v,
    output logic [BANK_W-1:0] iss_bank,
    output logic [COL_W-1:0]  iss_col,
    output logic              rd_err
);
    import sdr_rd_pkg::*;

    typedef struct packed {
        logic              run;
        logic              page;
        logic              err;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  base;
        logic [COL_W-1:0]  cnt;
        logic [COL_W-1:0]  lmask;
    } seq_t;

    seq_t seq_d, seq_q;
    logic legal;
    logic [COL_W-1:0] new_mask;

    always_comb begin
        legal    = rd_cmd && bank_on[rd_bank];
        new_mask = COL_W'(len_mask(len_code));
        seq_d     = seq_q;
        seq_d.err = rd_cmd && !bank_on[rd_bank];
        iss_v    = 1'b0;
        iss_bank = seq_q.bank;
        iss_col  = (seq_q.base & ~seq_q.lmask) | ((seq_q.base + seq_q.cnt) & seq_q.lmask);
        if (legal) begin
            iss_v       = 1'b1;
            iss_bank    = rd_bank;
            iss_col     = rd_col;
            seq_d.bank  = rd_bank;
            seq_d.base  = rd_col;
            seq_d.cnt   = COL_W'(1);
            seq_d.lmask = new_mask;
            seq_d.page  = is_page(len_code);
            seq_d.run   = is_page(len_code) || (new_mask != '0);
        end else if (seq_q.run) begin
            if (seq_q.page && stop_cmd) begin
                seq_d.run = 1'b0;
            end else begin
                iss_v     = 1'b1;
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (!seq_q.page && seq_q.cnt == seq_q.lmask) seq_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign rd_err = seq_q.err;

    // R2: full-page columns advance by one and wrap around the row
    a_r2_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && seq_q.page && !rd_cmd && !stop_cmd && $past(iss_v))
        |-> iss_col == COL_W'($past(iss_col) + 1'b1));

    // R5: a stop in full-page mode suppresses the word of that cycle
    a_r5_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && seq_q.page && stop_cmd && !rd_cmd) |-> !iss_v);
endmodule

// File: rtl/sdr_word_array.sv
module sdr_word_array #(
    parameter int ADDR_W = 9,
    parameter int DW     = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells_q[waddr] <= wdata;
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int BANK_W = 1,
    parameter int COL_W  = 8,
    parameter int DW     = 16,
    localparam int LW    = DW / 2,
    localparam int AW    = BANK_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cl3,
    input  logic              iss_v,
    input  logic [BANK_W-1:0] iss_bank,
    input  logic [COL_W-1:0]  iss_col,
    input  logic              dqm_hi,
    input  logic              dqm_lo,
    output logic [AW-1:0]     raddr,
    input  logic [DW-1:0]     rdata,
    output logic [DW-1:0]     dq_out,
    output logic              oe_hi,
    output logic              oe_lo
);
    typedef struct packed {
        logic              v;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } req_t;

    typedef struct packed {
        req_t          s0;
        req_t          s1;
        logic          dv;
        logic [DW-1:0] dq;
        logic          oe;
        logic [1:0]    m1;
        logic [1:0]    m2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    req_t  sel;
    logic  pre_v;
    logic [1:0] lane_en;

    always_comb begin
        sel    = cl3 ? pipe_q.s1 : pipe_q.s0;
        pre_v  = cl3 ? pipe_q.s0.v : iss_v;
        raddr  = {sel.bank, sel.col};
        pipe_d = pipe_q;
        pipe_d.s0 = '{v: iss_v, bank: iss_bank, col: iss_col};
        pipe_d.s1 = pipe_q.s0;
        pipe_d.dv = sel.v;
        pipe_d.dq = sel.v ? rdata : '0;
        pipe_d.oe = sel.v || pre_v;
        pipe_d.m1 = {dqm_hi, dqm_lo};
        pipe_d.m2 = pipe_q.m1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_en[g]             = pipe_q.oe && !pipe_q.m2[g];
        assign dq_out[g*LW +: LW]     = lane_en[g] ? pipe_q.dq[g*LW +: LW] : '0;
    end

    assign oe_hi = lane_en[1];
    assign oe_lo = lane_en[0];

    // R3: the drivers are already on in the cycle before the first word
    a_r3_oe_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pipe_q.dv) |-> $past(pipe_q.oe));

    // R3: a driven cycle without data is always followed by data
    a_r3_lead_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.oe && !pipe_q.dv) |=> pipe_q.dv);

    // R6: upper mask acts two cycles after it is sampled
    a_r6_mask_hi_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(dqm_hi, 2)) |-> !oe_hi);

    // R6: lower mask acts two cycles after it is sampled
    a_r6_mask_lo_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(dqm_lo, 2)) |-> !oe_lo);
endmodule

// File: rtl/sdr_burst_reader.sv
module sdr_burst_reader #(
    parameter int BANK_W = 1,
    parameter int COL_W  = 8,
    parameter int DW     = 16,
    localparam int NBANK = 1 << BANK_W,
    localparam int AW    = BANK_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_cmd,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              pre_cmd,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              rd_cmd,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              stop_cmd,
    input  logic              cfg_cl3,
    input  logic [2:0]        cfg_blen,
    input  logic              dqm_hi,
    input  logic              dqm_lo,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe_hi,
    output logic              dq_oe_lo,
    output logic              rd_err
);
    logic [NBANK-1:0]  bank_on;
    logic              iss_v;
    logic [BANK_W-1:0] iss_bank;
    logic [COL_W-1:0]  iss_col;
    logic [AW-1:0]     raddr;
    logic [DW-1:0]     rdata;

    sdr_bank_state #(.BANK_W(BANK_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .act_cmd(act_cmd), .act_bank(act_bank),
        .pre_cmd(pre_cmd), .pre_bank(pre_bank),
        .bank_on(bank_on)
    );

    sdr_col_seq #(.BANK_W(BANK_W), .COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .rd_cmd(rd_cmd), .rd_bank(rd_bank), .rd_col(rd_col),
        .stop_cmd(stop_cmd), .len_code(cfg_blen), .bank_on(bank_on),
        .iss_v(iss_v), .iss_bank(iss_bank), .iss_col(iss_col),
        .rd_err(rd_err)
    );

    sdr_word_array #(.ADDR_W(AW), .DW(DW)) u_array (
        .clk(clk), .we(wr_en), .waddr({wr_bank, wr_col}), .wdata(wr_data),
        .raddr(raddr), .rdata(rdata)
    );

    sdr_rd_pipe #(.BANK_W(BANK_W), .COL_W(COL_W), .DW(DW)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cl3(cfg_cl3),
        .iss_v(iss_v), .iss_bank(iss_bank), .iss_col(iss_col),
        .dqm_hi(dqm_hi), .dqm_lo(dqm_lo),
        .raddr(raddr), .rdata(rdata),
        .dq_out(dq_out), .oe_hi(dq_oe_hi), .oe_lo(dq_oe_lo)
    );

    // R7: a read to a closed bank is flagged in the next cycle
    a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !bank_on[rd_bank]) |=> rd_err);
endmodule

// File: tb/sdr_burst_reader_bench.sv
module sdr_burst_reader_bench;
    localparam int NB = 2, NC = 256, RING = 1024, FILL = 700;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, act_cmd, act_bank, pre_cmd, pre_bank, rd_cmd, rd_bank, stop_cmd;
    logic cfg_cl3, dqm_hi, dqm_lo, wr_en, wr_bank, dq_oe_hi, dq_oe_lo, rd_err;
    logic [7:0] rd_col, wr_col;
    logic [2:0] cfg_blen;
    logic [15:0] wr_data, dq_out;

    sdr_burst_reader u_sdr_burst_reader (
        .clk(clk), .rst_n(rst_n), .act_cmd(act_cmd), .act_bank(act_bank),
        .pre_cmd(pre_cmd), .pre_bank(pre_bank), .rd_cmd(rd_cmd), .rd_bank(rd_bank),
        .rd_col(rd_col), .stop_cmd(stop_cmd), .cfg_cl3(cfg_cl3), .cfg_blen(cfg_blen),
        .dqm_hi(dqm_hi), .dqm_lo(dqm_lo), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_col(wr_col), .wr_data(wr_data), .dq_out(dq_out), .dq_oe_hi(dq_oe_hi),
        .dq_oe_lo(dq_oe_lo), .rd_err(rd_err)
    );

    int unsigned n_cmp = 0, n_bad = 0;
    bit finished = 0, mon_on = 0;
    int cyc = 0;
    string tag = "R9";

    logic [15:0] ref_mem [NB*NC];
    bit ev [RING];
    logic [15:0] ew [RING];
    bit ee [RING], mh [RING], ml [RING];
    bit bk [NB];
    int m_cl = 2, m_bl = 1;
    bit m_pg = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string rq, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", rq, what, cyc, act, exp);
        end
    endtask

    function automatic int col_at(int col, int i, int bl);
        return (col & ~(bl - 1)) | ((col + i) & (bl - 1));
    endfunction

    function automatic int len_of(logic [2:0] code);
        case (code)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 256;
            default: return 1;
        endcase
    endfunction

    // per-cycle comparison against the expected timeline
    always @(negedge clk) begin
        if (mon_on) begin
            int k, kn;
            bit eoe, ehi, elo;
            logic [15:0] edq;
            k   = cyc % RING;
            kn  = (cyc + 1) % RING;
            eoe = ev[k] || ev[kn];
            ehi = eoe && !mh[k];
            elo = eoe && !ml[k];
            edq = {(ehi && ev[k]) ? ew[k][15:8] : 8'h00, (elo && ev[k]) ? ew[k][7:0] : 8'h00};
            chk(tag, "dq_oe_hi", int'(dq_oe_hi), int'(ehi));
            chk(tag, "dq_oe_lo", int'(dq_oe_lo), int'(elo));
            chk(tag, "dq_out", int'(dq_out), int'(edq));
            chk("R7", "rd_err", int'(rd_err), int'(ee[k]));
            ev[k] = 0; ee[k] = 0; mh[k] = 0; ml[k] = 0;
        end
    end

    task automatic nxt();
        @(negedge clk);
        act_cmd = 0; pre_cmd = 0; rd_cmd = 0; stop_cmd = 0;
        dqm_hi = 0; dqm_lo = 0; wr_en = 0;
    endtask

    task automatic kill_from(int from);
        for (int i = 0; i < FILL + 8; i++) ev[(from + i) % RING] = 0;
    endtask

    task automatic do_read(int b, int col);
        int n;
        rd_cmd = 1; rd_bank = b[0]; rd_col = col[7:0];
        if (bk[b]) begin
            kill_from(cyc + m_cl);
            n = m_pg ? FILL : m_bl;
            for (int i = 0; i < n; i++) begin
                ev[(cyc + m_cl + i) % RING] = 1;
                ew[(cyc + m_cl + i) % RING] = ref_mem[b*NC + col_at(col, i, m_bl)];
            end
        end else begin
            ee[(cyc + 1) % RING] = 1;
        end
    endtask

    task automatic do_stop();
        stop_cmd = 1;
        if (m_pg) kill_from(cyc + m_cl);
    endtask

    task automatic do_mask(bit h, bit l);
        dqm_hi = h; dqm_lo = l;
        mh[(cyc + 2) % RING] = h; ml[(cyc + 2) % RING] = l;
    endtask

    task automatic do_write(int b, int col, logic [15:0] d);
        wr_en = 1; wr_bank = b[0]; wr_col = col[7:0]; wr_data = d;
        ref_mem[b*NC + col] = d;
    endtask

    task automatic set_cfg(bit cl3, logic [2:0] code);
        cfg_cl3 = cl3; cfg_blen = code;
        m_cl = cl3 ? 3 : 2; m_bl = len_of(code); m_pg = (code == 3'd7);
    endtask

    task automatic drain();
        if (m_pg) begin nxt(); do_stop(); end
        repeat (14) nxt();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; act_bank = 0; pre_bank = 0; rd_bank = 0; rd_col = 0;
        wr_bank = 0; wr_col = 0; wr_data = 0;
        act_cmd = 0; pre_cmd = 0; rd_cmd = 0; stop_cmd = 0;
        dqm_hi = 0; dqm_lo = 0; wr_en = 0;
        set_cfg(0, 3'd0);
        repeat (4) @(negedge clk);
        rst_n = 1;
        mon_on = 1;

        // R9: reset state seen by the monitor, and banks closed
        tag = "R9";
        nxt(); do_read(0, 3);
        nxt(); do_read(1, 9);
        repeat (4) nxt();

        // R10: load the whole array
        tag = "R10";
        for (int i = 0; i < NB*NC; i++) begin
            nxt(); do_write(i / NC, i % NC, 16'($urandom));
        end
        nxt(); act_cmd = 1; act_bank = 0; bk[0] = 1;
        nxt(); act_cmd = 1; act_bank = 1; bk[1] = 1;
        nxt();

        // R1: single words at both latencies
        tag = "R1";
        set_cfg(0, 3'd0); nxt(); do_read(0, 17); drain();
        set_cfg(1, 3'd0); nxt(); do_read(1, 200); drain();

        // R2: wrap inside an aligned block and around a full row
        tag = "R2";
        set_cfg(0, 3'd3); nxt(); do_read(0, 13); drain();
        set_cfg(1, 3'd2); nxt(); do_read(1, 6); drain();
        set_cfg(0, 3'd7); nxt(); do_read(0, 250);
        repeat (20) nxt();
        do_stop(); drain();

        // R3: lead cycle before data at CL3
        tag = "R3";
        set_cfg(1, 3'd2); nxt(); do_read(0, 40); drain();
        // R4: drivers off after a two-word burst
        tag = "R4";
        set_cfg(0, 3'd1); nxt(); do_read(1, 33); drain();

        // R5: long full-page burst and stop ignored in fixed mode
        tag = "R5";
        set_cfg(1, 3'd7); nxt(); do_read(1, 100);
        repeat (300) nxt();
        do_stop(); drain();
        set_cfg(0, 3'd3); nxt(); do_read(0, 60);
        nxt(); nxt(); do_stop(); drain();

        // R6: independent byte masks
        tag = "R6";
        set_cfg(1, 3'd3); nxt(); do_read(0, 8);
        for (int i = 0; i < 12; i++) begin
            nxt(); do_mask(i % 3 == 0, i % 2 == 0);
        end
        drain();

        // R7: closed bank, also while a burst runs
        tag = "R7";
        nxt(); pre_cmd = 1; pre_bank = 1; bk[1] = 0;
        nxt(); do_read(1, 5);
        set_cfg(0, 3'd3); nxt(); do_read(0, 0);
        nxt(); do_read(1, 70); drain();
        nxt(); act_cmd = 1; act_bank = 1; bk[1] = 1;

        // R8: a new read takes over a running burst
        tag = "R8";
        set_cfg(0, 3'd3); nxt(); do_read(0, 0);
        nxt(); nxt(); nxt(); do_read(1, 50); drain();
        set_cfg(1, 3'd7); nxt(); do_read(0, 10);
        repeat (5) nxt();
        do_read(1, 255);
        repeat (6) nxt();
        drain();

        // R10: fresh word read back at once
        tag = "R10";
        set_cfg(0, 3'd0); nxt(); do_write(0, 77, 16'hbeef);
        nxt(); do_read(0, 77); drain();

        // random mix
        for (int r = 0; r < 40; r++) begin
            logic [2:0] codes [5];
            codes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
            set_cfg($urandom % 2, codes[$urandom % 5]);
            tag = m_pg ? "R5" : "R2";
            for (int t = 0; t < 60; t++) begin
                int a;
                nxt();
                a = $urandom % 10;
                if (a < 3)       do_read($urandom % 2, $urandom % NC);
                else if (a == 3) do_stop();
                else if (a == 4) begin
                    int b = $urandom % 2; pre_cmd = 1; pre_bank = b[0]; bk[b] = 0;
                end else if (a == 5) begin
                    int b = $urandom % 2; act_cmd = 1; act_bank = b[0]; bk[b] = 1;
                end
                if ($urandom % 4 == 0) do_mask($urandom % 2, $urandom % 2);
            end
            drain();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule